// File: doc/BRIEF.md
# Programmable Gold Sequence Generator

This block produces a binary scrambling stream by adding, modulo 2, the outputs of two independent Fibonacci shift-register lanes. Software sets for each lane the register degree (1 to 32), the feedback polynomial and a phase-select mask, and may load the lane state at any time. The selected bit of each lane is the parity of its state ANDed with the phase mask, so a suitable mask moves that lane's output to any point along its sequence without stepping the register there.

The host writes and reads configuration through a small word-addressed 32-bit bus. Address bit 2 chooses the lane (0 = lane A, 1 = lane B), and bits 1:0 choose the register inside the lane: 0 polynomial, 1 phase mask, 2 state, 3 degree. Each cycle in which `advance` is high, both lanes step once. In the following cycle `out_valid` is high and the output pins carry the bits that the lanes held before that step.

Top module: `gold_seq_gen`

## Requirements
- R1: After reset, each lane reads back polynomial 0x00000001, phase mask 0x80000000, state 0x00000001 and degree field 31, and `out_valid` is 0.
- R2: A write to address {lane, sel} updates only that register, and a read of the same address returns it through `bus_rdata` in the same cycle. Lane = bit 2 and sel = bits 1:0 (0 polynomial, 1 phase, 2 state, 3 degree).
- R3: On each advance, with degree m, new s0 is the XOR over j < m of poly[m-1-j] AND s_j, and each s_i (0 < i < m) takes the old s_(i-1).
- R4: Bit 0 of the polynomial register is always 1. A write with bit 0 clear reads back with it set and behaves like the same value with bit 0 set.
- R5: A lane's output bit is the parity of (phase mask AND state). The mask 1<<(m-1) gives the plain sequence, and 1<<(m-2) gives the bit that the plain sequence emits one advance later.
- R6: `gold_bit` equals `seq_a` XOR `seq_b` whenever `out_valid` is high.
- R7: The degree register holds m-1 in bits 4:0. State bits at positions m and above always read as zero, including after a state write or a degree change.
- R8: A state write in the same cycle as an advance loads the written value (masked to m bits) and that lane does not step.
- R9: An all-zero state stays all-zero through any number of advances, and that lane's output stays 0.
- R10: With a primitive polynomial of degree m and a nonzero state, the state returns to its start value after exactly 2^m - 1 advances.
- R11: `out_valid` is high exactly in the cycle after a cycle with `advance` high. The output bits in that cycle are computed from the state held before the step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Word address: bit 2 lane, bits 1:0 register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| advance | input | 1 | Step both lanes this cycle |
| out_valid | output | 1 | Output bits are valid |
| seq_a | output | 1 | Phase-selected bit of lane A |
| seq_b | output | 1 | Phase-selected bit of lane B |
| gold_bit | output | 1 | XOR of the two lane bits |

## Verification
A wrong feedback tap or shift makes a lane's masked bit disagree with the bench model within a few advances. The state readback then shows the error on the next read. A state bit left above the degree shows as a nonzero high bit on readback straight away, and it reaches the output only if the phase mask covers it, so the bench reads state directly. A fault in the load-over-advance ordering shows as a state one step off in the cycle after the write. A fault in the combining stage shows on `gold_bit` in the first valid cycle.

// File: rtl/gold_pkg.sv
package gold_pkg;

    localparam int MAX_DEG = 32;
    localparam int DEG_W   = $clog2(MAX_DEG);
    localparam int ADDR_W  = 3;
    localparam int LANES   = 2;

    typedef logic [MAX_DEG-1:0] word_t;
    typedef logic [DEG_W-1:0]   deg_t;

    typedef enum logic [1:0] {
        SEL_POLY  = 2'd0,
        SEL_PHASE = 2'd1,
        SEL_STATE = 2'd2,
        SEL_DEG   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        word_t poly;
        word_t phase;
        deg_t  deg_m1;
    } lane_cfg_t;

    typedef struct packed {
        logic valid;
        logic a;
        logic b;
        logic gold;
    } seq_out_t;

    localparam word_t POLY_RST  = word_t'(1);
    localparam word_t PHASE_RST = word_t'(1) << (MAX_DEG - 1);
    localparam word_t STATE_RST = word_t'(1);
    localparam deg_t  DEG_RST   = deg_t'(MAX_DEG - 1);

    // Ones in every position below the degree m = dm1 + 1.
    function automatic word_t deg_mask(input deg_t dm1);
        word_t m;
        for (int i = 0; i < MAX_DEG; i++)
            m[i] = (i <= int'(dm1));
        return m;
    endfunction

    // New s0: XOR over j < m of poly[m-1-j] & s[j].
    function automatic logic fib_feedback(input word_t st, input word_t poly, input deg_t dm1);
        logic fb;
        fb = 1'b0;
        for (int j = 0; j < MAX_DEG; j++) begin
            if (j <= int'(dm1))
                fb = fb ^ (poly[int'(dm1) - j] & st[j]);
        end
        return fb;
    endfunction

endpackage

// File: rtl/gold_lane_cfg.sv
module gold_lane_cfg
    import gold_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr,
    input  reg_sel_e   sel,
    input  word_t      wdata,
    output lane_cfg_t  cfg
);

    lane_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.poly   <= POLY_RST;
            cfg_q.phase  <= PHASE_RST;
            cfg_q.deg_m1 <= DEG_RST;
        end else if (wr) begin
            case (sel)
                SEL_POLY:  cfg_q.poly   <= wdata | word_t'(1);
                SEL_PHASE: cfg_q.phase  <= wdata;
                SEL_DEG:   cfg_q.deg_m1 <= wdata[DEG_W-1:0];
                default:   ;
            endcase
        end
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/gold_lfsr_core.sv
module gold_lfsr_core
    import gold_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       advance,
    input  logic       ld_state,
    input  logic       ld_deg,
    input  word_t      wdata,
    input  lane_cfg_t  cfg,
    output word_t      state,
    output word_t      active_mask,
    output logic       masked_bit
);

    word_t state_q;
    word_t state_d;
    word_t cur_mask;
    word_t new_mask;
    logic  fb;

    always_comb begin
        cur_mask = deg_mask(cfg.deg_m1);
        new_mask = deg_mask(wdata[DEG_W-1:0]);
        fb       = fib_feedback(state_q, cfg.poly, cfg.deg_m1);
        if (ld_state)
            state_d = wdata & cur_mask;
        else if (ld_deg)
            state_d = state_q & new_mask;
        else if (advance)
            state_d = {state_q[MAX_DEG-2:0], fb} & cur_mask;
        else
            state_d = state_q;
    end

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= STATE_RST;
        else
            state_q <= state_d;
    end

    assign state       = state_q;
    assign active_mask = cur_mask;
    assign masked_bit  = ^(cfg.phase & state_q);

endmodule

// File: rtl/gold_seq_gen.sv
module gold_seq_gen
    import gold_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [MAX_DEG-1:0]    bus_wdata,
    output logic [MAX_DEG-1:0]    bus_rdata,
    input  logic                  advance,
    output logic                  out_valid,
    output logic                  seq_a,
    output logic                  seq_b,
    output logic                  gold_bit
);

    reg_sel_e  sel;
    lane_cfg_t lane_cfg   [LANES];
    word_t     lane_state [LANES];
    word_t     lane_mask  [LANES];
    logic      lane_bit   [LANES];
    seq_out_t  out_q;

    assign sel = reg_sel_e'(bus_addr[1:0]);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic lane_wr;
        assign lane_wr = bus_wr && (int'(bus_addr[ADDR_W-1]) == g);

        gold_lane_cfg u_cfg (
            .clk   (clk),
            .rst   (rst),
            .wr    (lane_wr),
            .sel   (sel),
            .wdata (bus_wdata),
            .cfg   (lane_cfg[g])
        );

        gold_lfsr_core u_core (
            .clk         (clk),
            .rst         (rst),
            .advance     (advance),
            .ld_state    (lane_wr && sel == SEL_STATE),
            .ld_deg      (lane_wr && sel == SEL_DEG),
            .wdata       (bus_wdata),
            .cfg         (lane_cfg[g]),
            .state       (lane_state[g]),
            .active_mask (lane_mask[g]),
            .masked_bit  (lane_bit[g])
        );
    end

    always_comb begin
        lane_cfg_t c;
        c = lane_cfg[bus_addr[ADDR_W-1]];
        case (sel)
            SEL_POLY:  bus_rdata = c.poly;
            SEL_PHASE: bus_rdata = c.phase;
            SEL_STATE: bus_rdata = lane_state[bus_addr[ADDR_W-1]];
            default:   bus_rdata = {{(MAX_DEG-DEG_W){1'b0}}, c.deg_m1};
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q.valid <= advance;
            out_q.a     <= lane_bit[0];
            out_q.b     <= lane_bit[1];
            out_q.gold  <= lane_bit[0] ^ lane_bit[1];
        end
    end

    assign out_valid = out_q.valid;
    assign seq_a     = out_q.a;
    assign seq_b     = out_q.b;
    assign gold_bit  = out_q.gold;

endmodule

// File: rtl/gold_seq_gen_chk.sv
module gold_seq_gen_chk
    import gold_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              advance,
    input  logic              out_valid,
    input  logic              seq_a,
    input  logic              seq_b,
    input  logic              gold_bit,
    input  word_t             st_a,
    input  word_t             dm_a
);

    logic wr_lane_a;
    assign wr_lane_a = bus_wr && (bus_addr[ADDR_W-1] == 1'b0);

    a_r6_gold_xor: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (gold_bit == (seq_a ^ seq_b)));

    a_r11_valid_follows: assert property (@(posedge clk) disable iff (rst)
        advance |=> out_valid);

    a_r11_valid_idle: assert property (@(posedge clk) disable iff (rst)
        !advance |=> !out_valid);

    a_r7_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (st_a & ~dm_a) == '0);

    a_r9_zero_stays: assert property (@(posedge clk) disable iff (rst)
        (st_a == '0 && !(wr_lane_a && bus_addr[1:0] == SEL_STATE)) |=> st_a == '0);

    a_r8_load_wins: assert property (@(posedge clk) disable iff (rst)
        (wr_lane_a && bus_addr[1:0] == SEL_STATE && advance) |=> !out_valid || (st_a & ~dm_a) == '0);

    a_r3_shift: assert property (@(posedge clk) disable iff (rst)
        (advance && !wr_lane_a) |=> ((st_a >> 1) & (dm_a >> 1)) == ($past(st_a) & (dm_a >> 1)));

endmodule

bind gold_seq_gen gold_seq_gen_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .advance   (advance),
    .out_valid (out_valid),
    .seq_a     (seq_a),
    .seq_b     (seq_b),
    .gold_bit  (gold_bit),
    .st_a      (lane_state[0]),
    .dm_a      (lane_mask[0])
);

// File: tb/gold_seq_gen_test.sv
`timescale 1ns/1ps
module gold_seq_gen_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_wr;
    logic [2:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        advance;
    logic        out_valid, seq_a, seq_b, gold_bit;

    int checks = 0;
    int errors = 0;

    logic [31:0] m_poly  [2];
    logic [31:0] m_phase [2];
    logic [31:0] m_state [2];
    logic [4:0]  m_dm1   [2];

    always #5 clk = ~clk;

    gold_seq_gen uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .advance(advance),
        .out_valid(out_valid), .seq_a(seq_a), .seq_b(seq_b), .gold_bit(gold_bit)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mmask(input logic [4:0] dm1);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) r[i] = (i <= int'(dm1));
        return r;
    endfunction

    function automatic logic mbit(input int l);
        return ^(m_phase[l] & m_state[l]);
    endfunction

    function automatic logic [31:0] mnext(input int l);
        logic fb;
        int m;
        m = int'(m_dm1[l]) + 1;
        fb = 1'b0;
        for (int j = 0; j < m; j++) fb ^= m_poly[l][m-1-j] & m_state[l][j];
        return ((m_state[l] << 1) | {31'b0, fb}) & mmask(m_dm1[l]);
    endfunction

    task automatic bus_write(input int l, input int sel, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = {l[0], sel[1:0]}; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        case (sel)
            0: m_poly[l]  = d | 32'h1;
            1: m_phase[l] = d;
            2: m_state[l] = d & mmask(m_dm1[l]);
            default: begin m_dm1[l] = d[4:0]; m_state[l] &= mmask(d[4:0]); end
        endcase
    endtask

    task automatic bus_read(input int l, input int sel, output logic [31:0] d);
        bus_addr = {l[0], sel[1:0]};
        #1 d = bus_rdata;
    endtask

    task automatic step(input int n);
        logic ea, eb;
        @(negedge clk);
        advance = 1'b1;
        for (int k = 0; k < n; k++) begin
            ea = mbit(0); eb = mbit(1);
            if (k == n - 1) begin
                @(posedge clk); #1 advance = 1'b0; @(negedge clk);
            end else
                @(negedge clk);
            chk("R11 valid", {31'b0, out_valid}, 32'h1);
            chk("R3/R5 seq_a", {31'b0, seq_a}, {31'b0, ea});
            chk("R3/R5 seq_b", {31'b0, seq_b}, {31'b0, eb});
            chk("R6 gold", {31'b0, gold_bit}, {31'b0, ea ^ eb});
            m_state[0] = mnext(0);
            m_state[1] = mnext(1);
        end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 valid", {31'b0, out_valid}, 32'h0);
        for (int l = 0; l < 2; l++) begin
            bus_read(l, 0, d); chk("R1 poly", d, 32'h1);
            bus_read(l, 1, d); chk("R1 phase", d, 32'h8000_0000);
            bus_read(l, 2, d); chk("R1 state", d, 32'h1);
            bus_read(l, 3, d); chk("R1 deg", d, 32'd31);
        end
    endtask

    task automatic t_regmap();
        logic [31:0] d;
        bus_write(1, 1, 32'h0000_0010);
        bus_read(1, 1, d); chk("R2 phase B", d, 32'h10);
        bus_read(0, 1, d); chk("R2 phase A untouched", d, 32'h8000_0000);
    endtask

    task automatic t_period();
        logic [31:0] d;
        bus_write(0, 3, 32'd4);
        bus_write(0, 0, 32'h5);
        bus_write(0, 1, 32'h10);
        bus_write(0, 2, 32'h1);
        bus_write(1, 3, 32'd4);
        bus_write(1, 0, 32'h1D);
        bus_write(1, 1, 32'h10);
        bus_write(1, 2, 32'h3);
        step(30);
        bus_read(0, 2, d); chk("R10 not yet back", {31'b0, d == 32'h1}, 32'h0);
        step(1);
        bus_read(0, 2, d); chk("R10 period 31", d, 32'h1);
        bus_read(1, 2, d); chk("R10 period 31 lane B", d, 32'h3);
    endtask

    task automatic t_offset();
        logic rec [40];
        bus_write(0, 1, 32'h10);
        bus_write(0, 2, 32'h1);
        @(negedge clk); advance = 1'b1;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk); rec[k] = seq_a; m_state[0] = mnext(0); m_state[1] = mnext(1);
        end
        advance = 1'b0;
        bus_write(0, 1, 32'h08);
        bus_write(0, 2, 32'h1);
        @(negedge clk); advance = 1'b1;
        for (int k = 0; k < 39; k++) begin
            @(negedge clk);
            chk("R5 one-ahead mask", {31'b0, seq_a}, {31'b0, rec[k+1]});
            m_state[0] = mnext(0); m_state[1] = mnext(1);
        end
        advance = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_upper_bits();
        logic [31:0] d;
        bus_write(0, 2, 32'hFFFF_FFFF);
        bus_read(0, 2, d); chk("R7 masked load", d, 32'h1F);
        bus_write(0, 3, 32'd2);
        bus_read(0, 2, d); chk("R7 degree shrink", d, 32'h07);
        bus_read(0, 3, d); chk("R7 degree field", d, 32'd2);
        bus_write(0, 0, 32'h3);
        step(12);
        bus_read(0, 2, d); chk("R7 upper zero after run", d & ~32'h7, 32'h0);
        bus_write(0, 3, 32'd4);
    endtask

    task automatic t_priority();
        logic [31:0] d;
        @(negedge clk);
        advance = 1'b1; bus_wr = 1'b1; bus_addr = 3'b010; bus_wdata = 32'hFFFF_FF13;
        @(negedge clk);
        advance = 1'b0; bus_wr = 1'b0;
        m_state[0] = 32'h13; m_state[1] = mnext(1);
        bus_read(0, 2, d); chk("R8 load beats advance", d, 32'h13);
    endtask

    task automatic t_p0();
        logic [31:0] d;
        bus_write(0, 0, 32'h4);
        bus_read(0, 0, d); chk("R4 p0 forced", d, 32'h5);
        bus_write(0, 1, 32'h10);
        bus_write(0, 2, 32'h1);
        step(31);
        bus_read(0, 2, d); chk("R4 same period as 0x5", d, 32'h1);
    endtask

    task automatic t_zero();
        logic [31:0] d;
        bus_write(0, 2, 32'h0);
        bus_write(0, 1, 32'h1F);
        step(10);
        bus_read(0, 2, d); chk("R9 zero state held", d, 32'h0);
        chk("R9 output zero", {31'b0, seq_a}, 32'h0);
    endtask

    task automatic t_full();
        bus_write(0, 3, 32'd31);
        bus_write(0, 0, 32'h0040_0007);
        bus_write(0, 1, 32'h1234_5678);
        bus_write(0, 2, 32'h0000_ACE1);
        bus_write(1, 3, 32'd6);
        bus_write(1, 0, 32'h03);
        bus_write(1, 1, 32'h45);
        bus_write(1, 2, 32'h55);
        step(100);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; advance = 1'b0;
        for (int l = 0; l < 2; l++) begin
            m_poly[l] = 32'h1; m_phase[l] = 32'h8000_0000; m_state[l] = 32'h1; m_dm1[l] = 5'd31;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_regmap();
        t_period();
        t_offset();
        t_upper_bits();
        t_priority();
        t_p0();
        t_zero();
        t_full();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule